// File: doc/BRIEF.md
# Register-Controlled Eight-Pin I/O Port

This block manages a small port of general-purpose pins behind a simple word-wide register bus. The bus has a byte address, a write strobe, write data and read data. Software picks an electrical mode for each pin: driven output, input with pull-up, input with pull-down, or input with no pull. Software also sets the output data and enables the input sampling. Each pin's input is passed through a two-stage synchronizer before software can read it.

The output data register can be modified without a read-modify-write sequence. Three write-only addresses set, clear or invert the bits selected by ones in the write data. Any pin can be handed to one of eight peripheral signals instead of its data-out bit. That handover is controlled by a per-pin enable bit and a 3-bit selector. Two narrow alias windows write and read the mode fields of the lower four pins and of the upper four pins. These windows use the same storage as the full mode register.

All pad-facing outputs are registered. Read data is registered too: it appears one clock after the address is presented, and it reflects the register state before any write in that same cycle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0. Since mode 00 means driven output, `pin_oe` is all ones, while `pin_out`, `pull_up` and `pull_dn` are 0.
- R2: The 2-bit mode of pin n sits at bits [2n+1:2n] of the mode register (word offset 0x00). The encodings are: 00 drives the pin (`pin_oe`=1); 01 is input with `pull_up`=1; 10 is input with `pull_dn`=1; 11 is input with no pull and no drive.
- R3: A write to 0x14 sets every data-out bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to 0x18 clears every data-out bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to 0x1C inverts every data-out bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: When bit n of the peripheral-enable register (0x08) is 1, `pin_out[n]` follows `periph_sig[s]`. Here s is the 3-bit value in the select register of pin n, at 0x20+4n. The pin output lags the peripheral signal by one clock.
- R7: When peripheral-enable bit n is 0, `pin_out[n]` equals data-out bit n (0x0C).
- R8: The data-in register (0x10) returns the pad level after a two-flop synchronizer, ANDed with the input-enable register (0x04). A disabled pin reads 0.
- R9: The alias at 0x40 holds the mode fields of pins 0-3 in its bits [7:0], and the alias at 0x44 holds pins 4-7 in the same bits. Both aliases write and read the same storage as 0x00.
- R10: Reads of 0x14, 0x18 and 0x1C return 0. Select registers keep only 3 bits, so their upper bits read 0. Writes to 0x10 have no effect.
- R11: `bus_rdata` is registered. It shows the register addressed one clock earlier, with the state as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Asynchronous pad levels |
| periph_sig | input | 8 | Peripheral signals available for routing |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pull_up | output | 8 | Pull-up request per pin |
| pull_dn | output | 8 | Pull-down request per pin |

## Verification
The set, clear and toggle addresses are driven with overlapping and disjoint masks, and with ones above the pin range. This separates true masked updates from a plain overwrite and from a write that leaks into unrelated bits. The mode register is loaded with a pattern that uses all four encodings on two pins each; the pattern is then rewritten through each alias. This exposes swapped fields, wrong half placement and separate alias storage. The peripheral route is tried with two opposite peripheral vectors on pins with distinct selectors, including selector 7. The input path is sampled one clock after a pad change, which must still show the old level, and again after settling with full and partial input enables.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_DRIVE  = 2'b00,
    PM_PULLUP = 2'b01,
    PM_PULLDN = 2'b10,
    PM_FLOAT  = 2'b11
  } pin_mode_e;

  // word offsets (byte address >> 2)
  localparam int unsigned WOFF_MODE = 0;
  localparam int unsigned WOFF_INEN = 1;
  localparam int unsigned WOFF_PEN  = 2;
  localparam int unsigned WOFF_DOUT = 3;
  localparam int unsigned WOFF_DIN  = 4;
  localparam int unsigned WOFF_SET  = 5;
  localparam int unsigned WOFF_CLR  = 6;
  localparam int unsigned WOFF_TGL  = 7;
  localparam int unsigned WOFF_SEL0 = 8;

endpackage

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NPINS-1:0]      din_val,
  output logic [DATA_W-1:0]     rdata,
  output logic [2*NPINS-1:0]    mode_q,
  output logic [NPINS-1:0]      inen_q,
  output logic [NPINS-1:0]      pen_q,
  output logic [NPINS-1:0]      dout_q,
  output logic [NPINS-1:0][SEL_W-1:0] sel_q
);

  localparam int IDX_W   = ADDR_W - 2;
  localparam int MODE_W  = 2 * NPINS;
  localparam int HALF_W  = NPINS;
  localparam int WOFF_LO = WOFF_SEL0 + NPINS;
  localparam int WOFF_HI = WOFF_LO + 1;

  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] rd_next;
  logic [NPINS-1:0]  wmask;
  logic              unused_bits;

  assign widx        = addr[ADDR_W-1:2];
  assign wmask       = wdata[NPINS-1:0];
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:MODE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      inen_q <= '0;
      pen_q  <= '0;
      dout_q <= '0;
      sel_q  <= '0;
    end else if (we) begin
      if (widx == IDX_W'(WOFF_MODE)) mode_q <= wdata[MODE_W-1:0];
      if (widx == IDX_W'(WOFF_INEN)) inen_q <= wmask;
      if (widx == IDX_W'(WOFF_PEN))  pen_q  <= wmask;
      if (widx == IDX_W'(WOFF_DOUT)) dout_q <= wmask;
      if (widx == IDX_W'(WOFF_SET))  dout_q <= dout_q | wmask;
      if (widx == IDX_W'(WOFF_CLR))  dout_q <= dout_q & ~wmask;
      if (widx == IDX_W'(WOFF_TGL))  dout_q <= dout_q ^ wmask;
      if (widx == IDX_W'(WOFF_LO))   mode_q[HALF_W-1:0] <= wdata[HALF_W-1:0];
      if (widx == IDX_W'(WOFF_HI))   mode_q[MODE_W-1:HALF_W] <= wdata[HALF_W-1:0];
      for (int n = 0; n < NPINS; n++) begin
        if (widx == IDX_W'(WOFF_SEL0 + n)) sel_q[n] <= wdata[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (widx == IDX_W'(WOFF_MODE)) rd_next[MODE_W-1:0] = mode_q;
    if (widx == IDX_W'(WOFF_INEN)) rd_next[NPINS-1:0]  = inen_q;
    if (widx == IDX_W'(WOFF_PEN))  rd_next[NPINS-1:0]  = pen_q;
    if (widx == IDX_W'(WOFF_DOUT)) rd_next[NPINS-1:0]  = dout_q;
    if (widx == IDX_W'(WOFF_DIN))  rd_next[NPINS-1:0]  = din_val;
    if (widx == IDX_W'(WOFF_LO))   rd_next[HALF_W-1:0] = mode_q[HALF_W-1:0];
    if (widx == IDX_W'(WOFF_HI))   rd_next[HALF_W-1:0] = mode_q[MODE_W-1:HALF_W];
    for (int n = 0; n < NPINS; n++) begin
      if (widx == IDX_W'(WOFF_SEL0 + n)) rd_next[SEL_W-1:0] = sel_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R3
  set_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(WOFF_SET)) |=>
      ((dout_q & $past(wmask)) == $past(wmask)) &&
      ((dout_q & ~$past(wmask)) == ($past(dout_q) & ~$past(wmask))));

  // R4
  clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(WOFF_CLR)) |=>
      ((dout_q & $past(wmask)) == '0) &&
      ((dout_q & ~$past(wmask)) == ($past(dout_q) & ~$past(wmask))));

  // R5
  tgl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(WOFF_TGL)) |=> (dout_q == ($past(dout_q) ^ $past(wmask))));

  // R9
  alias_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(WOFF_HI)) |=>
      (mode_q[MODE_W-1:HALF_W] == $past(wdata[HALF_W-1:0])) &&
      $stable(mode_q[HALF_W-1:0]));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] inen,
  output logic [NPINS-1:0] din_val
);

  logic [NPINS-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)         stg[s] <= '0;
        else if (s == 0) stg[s] <= pad_in;
        else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign din_val = stg[STAGES-1] & inen;

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int SEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2*NPINS-1:0]          mode,
  input  logic [NPINS-1:0]            pen,
  input  logic [NPINS-1:0]            dout,
  input  logic [NPINS-1:0][SEL_W-1:0] sel,
  input  logic [(1<<SEL_W)-1:0]       periph,
  output logic [NPINS-1:0]            pin_out,
  output logic [NPINS-1:0]            pin_oe,
  output logic [NPINS-1:0]            pull_up,
  output logic [NPINS-1:0]            pull_dn
);

  genvar n;
  generate
    for (n = 0; n < NPINS; n++) begin : g_pin
      pin_mode_e md;
      assign md = pin_mode_e'(mode[2*n +: 2]);

      always_ff @(posedge clk) begin
        if (rst) begin
          pin_out[n] <= 1'b0;
          pin_oe[n]  <= 1'b1;
          pull_up[n] <= 1'b0;
          pull_dn[n] <= 1'b0;
        end else begin
          pin_out[n] <= pen[n] ? periph[sel[n]] : dout[n];
          pin_oe[n]  <= (md == PM_DRIVE);
          pull_up[n] <= (md == PM_PULLUP);
          pull_dn[n] <= (md == PM_PULLDN);
        end
      end

      // R2
      float_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode[2*n +: 2] == 2'b11) |=> (!pin_oe[n] && !pull_up[n] && !pull_dn[n]));

      // R7
      dout_path_chk: assert property (@(posedge clk) disable iff (rst)
        !pen[n] |=> (pin_out[n] == $past(dout[n])));

      // R6
      periph_path_chk: assert property (@(posedge clk) disable iff (rst)
        pen[n] |=> (pin_out[n] == $past(periph[sel[n]])));
    end
  endgenerate

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPINS     = 8,
  parameter int SEL_W     = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NPINS-1:0]        pad_in,
  input  logic [(1<<SEL_W)-1:0]   periph_sig,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS-1:0]        pin_oe,
  output logic [NPINS-1:0]        pull_up,
  output logic [NPINS-1:0]        pull_dn
);

  logic [2*NPINS-1:0]          mode_q;
  logic [NPINS-1:0]            inen_q, pen_q, dout_q, din_val;
  logic [NPINS-1:0][SEL_W-1:0] sel_q;

  gpio_bus_regs #(
    .NPINS(NPINS), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .din_val(din_val), .rdata(bus_rdata), .mode_q(mode_q), .inen_q(inen_q),
    .pen_q(pen_q), .dout_q(dout_q), .sel_q(sel_q)
  );

  gpio_in_sync #(
    .NPINS(NPINS), .STAGES(SYNC_STGS)
  ) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .inen(inen_q), .din_val(din_val)
  );

  gpio_pin_drive #(
    .NPINS(NPINS), .SEL_W(SEL_W)
  ) u_drive (
    .clk(clk), .rst(rst), .mode(mode_q), .pen(pen_q), .dout(dout_q),
    .sel(sel_q), .periph(periph_sig), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_dn(pull_dn)
  );

endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [7:0] A_MODE = 8'h00, A_INEN = 8'h04, A_PEN = 8'h08,
                         A_DOUT = 8'h0C, A_DIN = 8'h10, A_SET = 8'h14,
                         A_CLR = 8'h18, A_TGL = 8'h1C, A_SEL0 = 8'h20,
                         A_LO = 8'h40, A_HI = 8'h44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  periph_sig = '0;
  logic [7:0]  pin_out, pin_oe, pull_up, pull_dn;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .periph_sig(periph_sig), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_dn(pull_dn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_MODE, v); check("R1 mode", v, 0);
    rd(A_DOUT, v); check("R1 dout", v, 0);
    rd(A_PEN,  v); check("R1 pen", v, 0);
    rd(A_SEL0, v); check("R1 sel0", v, 0);
    check("R1 pin_oe", {24'h0, pin_oe}, 32'hFF);
    check("R1 pin_out/pulls", {8'h0, pin_out, pull_up, pull_dn}, 0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(A_MODE, 32'h0000_E4E4);
    settle();
    rd(A_MODE, v); check("R2 mode readback", v, 32'hE4E4);
    check("R2 pin_oe", {24'h0, pin_oe}, 32'h11);
    check("R2 pull_up", {24'h0, pull_up}, 32'h22);
    check("R2 pull_dn", {24'h0, pull_dn}, 32'h44);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(A_SET, 32'h0F); wr(A_SET, 32'h30);
    rd(A_DOUT, v); check("R3 set accum", v, 32'h3F);
    wr(A_SET, 32'hFFFF_FF00);
    rd(A_DOUT, v); check("R3 set upper bits", v, 32'h3F);
    settle();
    check("R7 pin_out=dout", {24'h0, pin_out}, 32'h3F);
  endtask

  task automatic t_clr();
    logic [31:0] v;
    wr(A_CLR, 32'h05);
    rd(A_DOUT, v); check("R4 clear", v, 32'h3A);
    settle();
    check("R7 pin_out after clear", {24'h0, pin_out}, 32'h3A);
  endtask

  task automatic t_tgl();
    logic [31:0] v;
    wr(A_TGL, 32'hFF);
    rd(A_DOUT, v); check("R5 toggle all", v, 32'hC5);
    wr(A_TGL, 32'h81);
    rd(A_DOUT, v); check("R5 toggle partial", v, 32'h44);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    rd(A_SET, v); check("R10 set reads 0", v, 0);
    rd(A_CLR, v); check("R10 clr reads 0", v, 0);
    rd(A_TGL, v); check("R10 tgl reads 0", v, 0);
    wr(A_SEL0 + 8'd8, 32'hFFFF_FFFF);
    rd(A_SEL0 + 8'd8, v); check("R10 sel upper bits", v, 32'h7);
    wr(A_DIN, 32'hFF);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(A_DIN, v); check("R10 din write ignored", v, 0);
    // R11: read in the same cycle as a write returns the old value
    @(negedge clk);
    bus_addr = A_DOUT; bus_we = 1'b1; bus_wdata = 32'h99;
    @(negedge clk);
    bus_we = 1'b0;
    check("R11 read before write", bus_rdata, 32'h44);
    @(negedge clk);
    check("R11 read after write", bus_rdata, 32'h99);
    wr(A_DOUT, 32'h44);
  endtask

  task automatic t_din();
    logic [31:0] v;
    @(negedge clk); pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    rd(A_DIN, v); check("R8 disabled reads 0", v, 0);
    wr(A_INEN, 32'hFF);
    rd(A_DIN, v); check("R8 full enable", v, 32'hA5);
    wr(A_INEN, 32'h0F);
    rd(A_DIN, v); check("R8 partial enable", v, 32'h05);
    @(negedge clk);
    pad_in = 8'h5A; bus_addr = A_DIN;
    @(negedge clk);
    check("R8 sync delay", bus_rdata, 32'h05);
    repeat (3) @(negedge clk);
    check("R8 new level", bus_rdata, 32'h0A);
  endtask

  task automatic t_periph();
    wr(A_SEL0 + 8'd0, 32'h1);
    wr(A_SEL0 + 8'd4, 32'h0);
    wr(A_SEL0 + 8'd8, 32'h7);
    @(negedge clk); periph_sig = 8'hA6;
    settle();
    check("R7 pen off", {24'h0, pin_out}, 32'h44);
    wr(A_PEN, 32'h07);
    settle();
    check("R6 periph route A", {24'h0, pin_out}, 32'h45);
    @(negedge clk); periph_sig = 8'h59;
    settle();
    check("R6 periph route B", {24'h0, pin_out}, 32'h42);
    wr(A_PEN, 32'h00);
    settle();
    check("R7 back to dout", {24'h0, pin_out}, 32'h44);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(A_LO, 32'hFFFF_FF1B);
    rd(A_MODE, v); check("R9 low alias into mode", v, 32'hE41B);
    rd(A_LO, v);   check("R9 low alias read", v, 32'h1B);
    rd(A_HI, v);   check("R9 high alias read", v, 32'hE4);
    wr(A_HI, 32'h00);
    rd(A_MODE, v); check("R9 high alias into mode", v, 32'h001B);
    settle();
    check("R2 pin_oe via alias", {24'h0, pin_oe}, 32'hF8);
    check("R2 pull_up via alias", {24'h0, pull_up}, 32'h04);
    check("R2 pull_dn via alias", {24'h0, pull_dn}, 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode();
    t_set();
    t_clr();
    t_tgl();
    t_misc();
    t_din();
    t_periph();
    t_alias();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule